// File: doc/BRIEF.md
# Nonvolatile Commit and Busy Controller

This block sits between a byte-addressed register shadow and a slow nonvolatile store. A bus slave reports every accepted data byte with a write strobe, and reports the START (first or repeated) and STOP conditions it sees. The controller keeps a dirty mask for one row of the store. When a write transaction closes with STOP, it copies the written bytes of that row into the store and then holds a busy flag for a fixed number of clock cycles. The slave uses the busy flag to refuse its device address, so a master can poll until the commit is finished.

A repeated START cancels the pending commit. The live settings keep their new values and no busy time is spent. A shadow-enable control bit, when set, turns every write into a volatile-only update: nothing is sent to the store and nothing is counted. Completed commits are counted in a saturating counter. After reset, a single load strobe asks the store to reload the shadow.

Top module: `nv_commit_ctrl`

## Requirements
- R1: After reset `busy`, `nv_wr_stb` and `commit_count` are 0, and `nv_load_stb` is high for exactly one clock cycle shortly after reset is released.
- R2: A `bus_stop` sampled with `shadow_en`=0, `busy`=0, no `bus_start` in the same cycle and at least one recorded byte raises `busy` in the next cycle. `busy` then stays high for exactly WRITE_CYCLES cycles.
- R3: During a commit, each recorded byte is written to the store exactly once, in ascending byte index (bits [2:0] of the address), one per cycle. The first write is one cycle after `busy` rises. The data is the last value written to that byte, and bytes that were not written are not sent to the store.
- R4: A `bus_start` (first or repeated) sampled while `busy`=0 discards all recorded bytes. A later STOP with no new writes then causes no busy time and no store write.
- R5: A `bus_stop` sampled with `shadow_en`=1 discards the recorded bytes without raising `busy`, without a store write and without changing `commit_count`.
- R6: While `busy`=1, `wr_stb`, `bus_start` and `bus_stop` are ignored. A commit already in progress is neither extended nor changed, and it is not restarted.
- R7: The row is taken from address bits [7:3] of the first byte recorded after the mask was empty. Later bytes of the same transaction use only bits [2:0], so they wrap within that row.
- R8: `commit_count` rises by one in the cycle in which `busy` falls, and it saturates at its all-ones value.
- R9: A strobe in the same cycle as a qualifying `bus_stop` is included in the commit. A strobe in the same cycle as `bus_start` is kept as the first byte of the new transaction.
- R10: A `bus_stop` with no recorded byte and no strobe in the same cycle does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Byte accepted by the bus slave |
| wr_addr | input | ADDR_W | Address of the accepted byte |
| wr_data | input | DATA_W | Value of the accepted byte |
| bus_start | input | 1 | START or repeated START seen on the bus |
| bus_stop | input | 1 | STOP seen on the bus |
| shadow_en | input | 1 | 1: writes update the shadow only |
| busy | output | 1 | Commit in progress; the slave refuses its address |
| nv_wr_stb | output | 1 | Store write strobe |
| nv_wr_addr | output | ADDR_W | Store write address |
| nv_wr_data | output | DATA_W | Store write data |
| nv_load_stb | output | 1 | One-cycle reload request after reset |
| commit_count | output | CNT_W | Saturating count of completed commits |

## Verification
Two functions can fall in the same cycle: recording a byte and reacting to a bus boundary. The bench raises `wr_stb` together with `bus_stop`, and expects the byte to appear in the commit that follows. It then raises `wr_stb` together with `bus_start` while an older byte is pending, and expects only the new byte to reach the store. A third overlap is a strobe, START or STOP during the busy window. It is judged by the exact busy length and the exact list of store writes.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/nvc_dirty_row.sv
module nvc_dirty_row #(
  parameter int ROW_BYTES = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = $clog2(ROW_BYTES),
  localparam int ROW_W    = ADDR_W - IDX_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              busy,
  input  logic                              wr_stb,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic                              bus_start,
  input  logic                              bus_stop,
  input  logic                              shadow_en,
  input  logic                              pop_en,
  input  logic [IDX_W-1:0]                  pop_idx,
  output logic [ROW_BYTES-1:0]              mask_q,
  output logic [ROW_W-1:0]                  row_q,
  output logic [ROW_BYTES-1:0][DATA_W-1:0]  bytes_q
);

  logic                 accept;
  logic                 clr_on_start;
  logic                 drop_on_stop;
  logic [IDX_W-1:0]     widx;
  logic [ROW_BYTES-1:0] mask_base;
  logic [ROW_BYTES-1:0] mask_d;
  logic                 row_en;

  // next-state: start clears first, a strobe then sets, a shadow-only stop drops all
  always_comb begin
    accept       = wr_stb & ~busy;
    clr_on_start = bus_start & ~busy;
    drop_on_stop = bus_stop & shadow_en & ~busy;
    widx         = wr_addr[IDX_W-1:0];
    mask_base    = clr_on_start ? '0 : mask_q;
    row_en       = accept & (mask_base == '0);
    mask_d       = mask_base;
    if (accept)       mask_d[widx]    = 1'b1;
    if (drop_on_stop) mask_d          = '0;
    if (pop_en)       mask_d[pop_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (row_en) begin
      row_q <= wr_addr[ADDR_W-1:IDX_W];
    end
  end

  for (genvar gi = 0; gi < ROW_BYTES; gi++) begin : g_byte
    logic byte_en;
    assign byte_en = accept & (widx == IDX_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bytes_q[gi] <= '0;
      end else if (byte_en) begin
        bytes_q[gi] <= wr_data;
      end
    end
  end

  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((mask_q & ~$past(mask_q)) == '0)); // R6

  AST_SHADOW_DROPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_stop && shadow_en) |=> (mask_q == '0)); // R5

endmodule

// File: rtl/nvc_commit_seq.sv
module nvc_commit_seq
  import nvc_pkg::*;
#(
  parameter int ROW_BYTES    = 8,
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 40,
  localparam int IDX_W       = $clog2(ROW_BYTES),
  localparam int ROW_W       = ADDR_W - IDX_W,
  localparam int TMR_W       = $clog2(WRITE_CYCLES + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_start,
  input  logic                              bus_stop,
  input  logic                              shadow_en,
  input  logic                              wr_stb,
  input  logic [ROW_BYTES-1:0]              mask_q,
  input  logic [ROW_W-1:0]                  row_q,
  input  logic [ROW_BYTES-1:0][DATA_W-1:0]  bytes_q,
  output logic                              busy,
  output logic                              pop_en,
  output logic [IDX_W-1:0]                  pop_idx,
  output logic                              done,
  output logic                              nv_wr_stb,
  output logic [ADDR_W-1:0]                 nv_wr_addr,
  output logic [DATA_W-1:0]                 nv_wr_data,
  output logic                              nv_load_stb
);

  seq_state_e       state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             go;
  logic             loaded_q;
  logic             load_q;

  function automatic logic [IDX_W-1:0] lowest_set(input logic [ROW_BYTES-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ROW_BYTES - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  initial begin
    AST_WINDOW_FITS_ROW: assert (WRITE_CYCLES > ROW_BYTES); // R3
  end

  // next-state logic
  always_comb begin
    go      = bus_stop & ~bus_start & ~shadow_en & ((mask_q != '0) | wr_stb);
    state_d = state_q;
    tmr_d   = tmr_q;
    done    = 1'b0;
    pop_en  = 1'b0;
    pop_idx = lowest_set(mask_q);
    case (state_q)
      SEQ_IDLE: begin
        if (go) begin
          state_d = SEQ_BUSY;
          tmr_d   = TMR_W'(WRITE_CYCLES - 1);
        end
      end
      SEQ_BUSY: begin
        pop_en = (mask_q != '0);
        if (tmr_q == '0) begin
          state_d = SEQ_IDLE;
          done    = 1'b1;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  assign busy = (state_q == SEQ_BUSY);

  // store write port, registered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_wr_stb <= 1'b0;
    end else begin
      nv_wr_stb <= pop_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_wr_addr <= '0;
      nv_wr_data <= '0;
    end else if (pop_en) begin
      nv_wr_addr <= {row_q, pop_idx};
      nv_wr_data <= bytes_q[pop_idx];
    end
  end

  // one reload request after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      load_q   <= 1'b0;
    end else begin
      loaded_q <= 1'b1;
      load_q   <= ~loaded_q;
    end
  end

  assign nv_load_stb = load_q;

  // checker counter for the busy window
  logic [TMR_W:0] chk_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_run_q <= '0;
    end else if (busy) begin
      chk_run_q <= chk_run_q + 1'b1;
    end else begin
      chk_run_q <= '0;
    end
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (chk_run_q == (TMR_W + 1)'(WRITE_CYCLES))); // R2

  AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_stop)); // R2

  AST_STORE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr_stb |-> busy); // R3

  AST_SHADOW_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_stop && shadow_en) |=> !busy); // R5

  AST_EMPTY_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_stop && !wr_stb && (mask_q == '0)) |=> !busy); // R10

endmodule

// File: rtl/nvc_wear_counter.sv
module nvc_wear_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  output logic [CNT_W-1:0] commit_count
);

  logic             cnt_en;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_en = done & (commit_count != {CNT_W{1'b1}});
    cnt_d  = commit_count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_count <= '0;
    end else if (cnt_en) begin
      commit_count <= cnt_d;
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(commit_count) |-> (commit_count == CNT_W'($past(commit_count) + 1'b1))); // R8

  AST_COUNT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(commit_count) |-> $past(done)); // R8

endmodule

// File: rtl/nv_commit_ctrl.sv
module nv_commit_ctrl #(
  parameter int ROW_BYTES    = 8,
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 40,
  parameter int CNT_W        = 16,
  localparam int IDX_W       = $clog2(ROW_BYTES),
  localparam int ROW_W       = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              shadow_en,
  output logic              busy,
  output logic              nv_wr_stb,
  output logic [ADDR_W-1:0] nv_wr_addr,
  output logic [DATA_W-1:0] nv_wr_data,
  output logic              nv_load_stb,
  output logic [CNT_W-1:0]  commit_count
);

  logic [1:0]                        rst_sync_q;
  logic                              rst_n_i;
  logic [ROW_BYTES-1:0]              mask_q;
  logic [ROW_W-1:0]                  row_q;
  logic [ROW_BYTES-1:0][DATA_W-1:0]  bytes_q;
  logic                              pop_en;
  logic [IDX_W-1:0]                  pop_idx;
  logic                              done;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_i = rst_sync_q[1];

  nvc_dirty_row #(
    .ROW_BYTES (ROW_BYTES),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) i_dirty_row (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .busy      (busy),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .shadow_en (shadow_en),
    .pop_en    (pop_en),
    .pop_idx   (pop_idx),
    .mask_q    (mask_q),
    .row_q     (row_q),
    .bytes_q   (bytes_q)
  );

  nvc_commit_seq #(
    .ROW_BYTES    (ROW_BYTES),
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .WRITE_CYCLES (WRITE_CYCLES)
  ) i_commit_seq (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .bus_start   (bus_start),
    .bus_stop    (bus_stop),
    .shadow_en   (shadow_en),
    .wr_stb      (wr_stb),
    .mask_q      (mask_q),
    .row_q       (row_q),
    .bytes_q     (bytes_q),
    .busy        (busy),
    .pop_en      (pop_en),
    .pop_idx     (pop_idx),
    .done        (done),
    .nv_wr_stb   (nv_wr_stb),
    .nv_wr_addr  (nv_wr_addr),
    .nv_wr_data  (nv_wr_data),
    .nv_load_stb (nv_load_stb)
  );

  nvc_wear_counter #(
    .CNT_W (CNT_W)
  ) i_wear_counter (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .done         (done),
    .commit_count (commit_count)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(rst_n_i) |-> (!busy && !nv_wr_stb && (commit_count == '0))); // R1

endmodule

// File: tb/test_nv_commit_ctrl.sv
module test_nv_commit_ctrl;
  localparam int W    = 12;
  localparam int CW   = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_stb = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          bus_start = 1'b0;
  logic          bus_stop = 1'b0;
  logic          shadow_en = 1'b0;
  logic          busy;
  logic          nv_wr_stb;
  logic [7:0]    nv_wr_addr;
  logic [7:0]    nv_wr_data;
  logic          nv_load_stb;
  logic [CW-1:0] commit_count;

  nv_commit_ctrl #(
    .ROW_BYTES (8), .ADDR_W (8), .DATA_W (8), .WRITE_CYCLES (W), .CNT_W (CW)
  ) i_nv_commit_ctrl (
    .clk (clk), .rst_n (rst_n), .wr_stb (wr_stb), .wr_addr (wr_addr),
    .wr_data (wr_data), .bus_start (bus_start), .bus_stop (bus_stop),
    .shadow_en (shadow_en), .busy (busy), .nv_wr_stb (nv_wr_stb),
    .nv_wr_addr (nv_wr_addr), .nv_wr_data (nv_wr_data),
    .nv_load_stb (nv_load_stb), .commit_count (commit_count)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  int c1 = 0;
  int busy_n = 0;
  int load_n = 0;
  int n_log = 0;
  int lg_a [0:15];
  int lg_d [0:15];
  int lg_c [0:15];
  int ex_a [0:7];
  int ex_d [0:7];
  int exp_count = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (busy === 1'b1) busy_n = busy_n + 1;
    if (nv_load_stb === 1'b1) load_n = load_n + 1;
    if (nv_wr_stb === 1'b1 && n_log < 16) begin
      lg_a[n_log] = int'(nv_wr_addr);
      lg_d[n_log] = int'(nv_wr_data);
      lg_c[n_log] = cyc;
      n_log = n_log + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic p_wr(input logic [7:0] a, input logic [7:0] d);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic p_start();
    bus_start = 1'b1;
    @(negedge clk);
    bus_start = 1'b0;
  endtask

  task automatic p_stop();
    bus_stop = 1'b1;
    @(negedge clk);
    bus_stop = 1'b0;
  endtask

  // stop pulse (optionally with a strobe in the same cycle), then busy check
  task automatic launch(input bit with_wr, input logic [7:0] a, input logic [7:0] d,
                        input bit exp_commit);
    n_log = 0;
    busy_n = 0;
    bus_stop = 1'b1;
    if (with_wr) begin
      wr_stb = 1'b1; wr_addr = a; wr_data = d;
    end
    @(negedge clk);
    bus_stop = 1'b0;
    wr_stb = 1'b0;
    c1 = cyc;
    check("R2 busy in cycle after STOP", int'(busy), int'(exp_commit));
  endtask

  task automatic finish(input int nexp, input bit exp_commit, input string req);
    int old_count;
    old_count = exp_count;
    if (exp_commit) exp_count = (exp_count == CMAX) ? CMAX : exp_count + 1;
    while (cyc < c1 + W - 1) @(negedge clk);
    check("R2 busy held to last cycle", int'(busy), int'(exp_commit));
    check("R8 count unchanged before busy falls", int'(commit_count), old_count);
    @(negedge clk);
    check("R2 busy low after window", int'(busy), 0);
    check("R8 count when busy falls", int'(commit_count), exp_count);
    repeat (3) @(negedge clk);
    check("R2 busy cycle total", busy_n, exp_commit ? W : 0);
    check({req, " store write count"}, n_log, nexp);
    for (int k = 0; k < nexp && k < n_log; k++) begin
      check({req, " store address"}, lg_a[k], ex_a[k]);
      check({req, " store data"}, lg_d[k], ex_d[k]);
      check("R3 store write cycle", lg_c[k], c1 + 1 + k);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R1 load pulse count", load_n, 1);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 store strobe after reset", int'(nv_wr_stb), 0);
    check("R1 count after reset", int'(commit_count), 0);
  endtask

  task automatic t_single();
    p_start();
    p_wr(8'h05, 8'hA5);
    ex_a[0] = 'h05; ex_d[0] = 'hA5;
    launch(1'b0, 8'h00, 8'h00, 1'b1);
    finish(1, 1'b1, "R3 single byte");
  endtask

  task automatic t_row_wrap();
    p_start();
    p_wr(8'h1E, 8'h11);
    p_wr(8'h1B, 8'h22);
    p_wr(8'h21, 8'h33);
    p_wr(8'h1B, 8'h44);
    ex_a[0] = 'h19; ex_d[0] = 'h33;
    ex_a[1] = 'h1B; ex_d[1] = 'h44;
    ex_a[2] = 'h1E; ex_d[2] = 'h11;
    launch(1'b0, 8'h00, 8'h00, 1'b1);
    finish(3, 1'b1, "R7 row wrap and R3 order");
  endtask

  task automatic t_rep_start();
    p_start();
    p_wr(8'h02, 8'h77);
    p_start();
    launch(1'b0, 8'h00, 8'h00, 1'b0);
    finish(0, 1'b0, "R4 repeated START cancels");
    p_start();
    p_wr(8'h63, 8'h01);
    p_start();
    p_wr(8'h0A, 8'h5C);
    ex_a[0] = 'h0A; ex_d[0] = 'h5C;
    launch(1'b0, 8'h00, 8'h00, 1'b1);
    finish(1, 1'b1, "R4 only new transaction");
  endtask

  task automatic t_shadow();
    shadow_en = 1'b1;
    p_start();
    p_wr(8'h10, 8'hEE);
    launch(1'b0, 8'h00, 8'h00, 1'b0);
    finish(0, 1'b0, "R5 shadow only");
    shadow_en = 1'b0;
    launch(1'b0, 8'h00, 8'h00, 1'b0);
    finish(0, 1'b0, "R10 empty STOP after shadow");
  endtask

  task automatic t_busy_ignore();
    p_start();
    p_wr(8'h30, 8'h9D);
    ex_a[0] = 'h30; ex_d[0] = 'h9D;
    launch(1'b0, 8'h00, 8'h00, 1'b1);
    p_wr(8'h31, 8'h42);
    p_start();
    p_wr(8'h35, 8'h43);
    p_stop();
    finish(1, 1'b1, "R6 ignored while busy");
    launch(1'b0, 8'h00, 8'h00, 1'b0);
    finish(0, 1'b0, "R6 nothing left pending");
  endtask

  task automatic t_same_cycle();
    p_start();
    p_wr(8'h40, 8'hC1);
    ex_a[0] = 'h40; ex_d[0] = 'hC1;
    ex_a[1] = 'h43; ex_d[1] = 'hC4;
    launch(1'b1, 8'h43, 8'hC4, 1'b1);
    finish(2, 1'b1, "R9 strobe with STOP");
    p_start();
    p_wr(8'h57, 8'hB7);
    bus_start = 1'b1; wr_stb = 1'b1; wr_addr = 8'h50; wr_data = 8'hB0;
    @(negedge clk);
    bus_start = 1'b0; wr_stb = 1'b0;
    ex_a[0] = 'h50; ex_d[0] = 'hB0;
    launch(1'b0, 8'h00, 8'h00, 1'b1);
    finish(1, 1'b1, "R9 strobe with START");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 2; i++) begin
      p_start();
      p_wr(8'h70, 8'(i));
      ex_a[0] = 'h70; ex_d[0] = i;
      launch(1'b0, 8'h00, 8'h00, 1'b1);
      finish(1, 1'b1, "R8 saturation run");
    end
    check("R8 saturated count", int'(commit_count), CMAX);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_single();
        t_row_wrap();
        t_rep_start();
        t_shadow();
        t_busy_ignore();
        t_same_cycle();
        t_saturate();
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule